// File: doc/BRIEF.md
# Little-Endian Load/Store Unit

This block sits between an integer core's execute stage and a byte-addressable data memory that has a 32-bit word bus. When the core raises a request strobe, the block takes in several values: the base register value, a 12-bit offset, the 3-bit width code, a store/load select and the store data. In the same cycle it adds the sign-extended offset to the base and drives the memory with a word-aligned address. For stores it also drives one write enable per byte lane and store data that has been shifted onto the addressed lanes. Byte order is little-endian: the least significant byte of a value goes to the lowest address.

The memory is synchronous and returns read data one cycle after the access. In that cycle the block raises a one-cycle done pulse. It picks the addressed byte or halfword out of the returned word and extends it to 32 bits, using sign or zero extension as the width code asks. A request that is misaligned for its width does not reach memory and raises a flag. A request with an unsupported width code is also dropped.

Top module: `lsu_core`

## Requirements
- R1: The effective address is base plus the 12-bit offset sign-extended from its bit 11. For an accepted request, mem_req is high in the request cycle and mem_addr is the effective address with its two low bits cleared.
- R2: A byte store (code 000) enables only lane ea[1:0], where lane k carries bits 8k+7..8k. The low byte of the store data appears on all four lanes.
- R3: A halfword store (code 001) with ea[0]=0 enables lanes 2*ea[1] and 2*ea[1]+1. The low 16 bits of the store data appear in both halves of mem_wdata.
- R4: A word store (code 010) with ea[1:0]=00 enables all four lanes and passes the store data through unchanged.
- R5: A halfword access with ea[0]=1 or a word access with ea[1:0]≠00 raises misaligned in the request cycle. It then asserts no write enable and no mem_req, and produces no done pulse.
- R6: A load never asserts any write enable.
- R7: ld_done is high for exactly one cycle, the cycle after an accepted load. It is never high after a store, and it is low out of reset.
- R8: A signed byte load (code 000) returns lane ea[1:0] sign-extended from bit 7. An unsigned byte load (code 100) returns the same lane zero-extended.
- R9: A signed halfword load (code 001) returns lanes 2*ea[1]+1 and 2*ea[1], with the higher lane as the upper byte, sign-extended from bit 15. An unsigned halfword load (code 101) zero-extends the same value.
- R10: A word load (code 010) returns the memory word unchanged.
- R11: Unsupported codes produce no mem_req, no write enable, no done pulse and no misaligned flag. The unsupported codes are 011, 110 and 111 for loads, and 011 or any code with bit 2 set for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_width | input | 3 | Width/extension code |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed byte offset |
| req_wdata | input | 32 | Store data |
| mem_req | output | 1 | Memory access enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, one cycle after mem_req |
| misaligned | output | 1 | Alignment fault for the current request |
| ld_done | output | 1 | Load result valid pulse |
| ld_data | output | 32 | Extended load result |

## Verification
Address, enables, steered write data and the misaligned flag are combinational. The bench therefore checks them 2 ns after it drives a request, inside the request cycle. A load result is due one clock edge later, so the driver pushes the expected value into a queue and a monitor samples ld_done 5 ns after each rising edge, pops the queue and compares. The expected value comes from a shadow byte array that the bench updates from the requirements, not from the write enables the design drives. A done pulse that arrives with an empty queue is a failure, and so is a queue left non-empty at the end. Both catch done pulses that are missing or extra after stores, misaligned requests and unsupported codes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef struct packed {
        logic       done;
        logic [1:0] lane;
        size_e      size;
        logic       uns;
    } track_t;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFS_W = 12
) (
    input  logic             valid,
    input  logic             store,
    input  logic [2:0]       width,
    input  logic [XLEN-1:0]  base,
    input  logic [OFS_W-1:0] offset,
    output logic [XLEN-1:0]  ea,
    output size_e            size,
    output logic             uns,
    output logic             misalign,
    output logic             access
);
    logic supported;
    logic bad_align;

    always_comb begin
        ea        = base + {{(XLEN-OFS_W){offset[OFS_W-1]}}, offset};
        size      = size_e'(width[1:0]);
        uns       = width[2];
        supported = (size != SZ_BAD) && !(uns && (store || size == SZ_WORD));
        unique case (size)
            SZ_HALF: bad_align = ea[0];
            SZ_WORD: bad_align = (ea[1:0] != 2'b00);
            default: bad_align = 1'b0;
        endcase
        misalign = valid && supported && bad_align;
        access   = valid && supported && !bad_align;
    end
endmodule

// File: rtl/lsu_wr_steer.sv
module lsu_wr_steer
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                     en,
    input  size_e                    size,
    input  logic [$clog2(XLEN/8)-1:0] lane,
    input  logic [XLEN-1:0]          sdata,
    output logic [XLEN/8-1:0]        we,
    output logic [XLEN-1:0]          wdata
);
    localparam int LANES = XLEN / 8;
    localparam int LW    = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LW-1:0] IDX = LW'(i);
        always_comb begin
            unique case (size)
                SZ_BYTE: we[i] = en && (lane == IDX);
                SZ_HALF: we[i] = en && (lane[LW-1:1] == IDX[LW-1:1]);
                SZ_WORD: we[i] = en;
                default: we[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: wdata = {LANES{sdata[7:0]}};
            SZ_HALF: wdata = {(LANES/2){sdata[15:0]}};
            default: wdata = sdata;
        endcase
    end
endmodule

// File: rtl/lsu_rd_extract.sv
module lsu_rd_extract
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]           rdata,
    input  size_e                     size,
    input  logic                      uns,
    input  logic [$clog2(XLEN/8)-1:0] lane,
    output logic [XLEN-1:0]           data
);
    localparam int LW = $clog2(XLEN / 8);

    logic [7:0]  byte_v;
    logic [15:0] half_v;

    always_comb begin
        byte_v = rdata[8*int'(lane) +: 8];
        half_v = rdata[16*int'(lane[LW-1:1]) +: 16];
        unique case (size)
            SZ_BYTE: data = uns ? {{(XLEN-8){1'b0}}, byte_v}
                                : {{(XLEN-8){byte_v[7]}}, byte_v};
            SZ_HALF: data = uns ? {{(XLEN-16){1'b0}}, half_v}
                                : {{(XLEN-16){half_v[15]}}, half_v};
            default: data = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFS_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [2:0]         req_width,
    input  logic [XLEN-1:0]    req_base,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [XLEN-1:0]    req_wdata,
    output logic               mem_req,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN/8-1:0]  mem_we,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic               misaligned,
    output logic               ld_done,
    output logic [XLEN-1:0]    ld_data
);
    localparam int LANES = XLEN / 8;
    localparam int LW    = $clog2(LANES);

    logic [XLEN-1:0] ea;
    size_e           size;
    logic            uns;
    logic            access;
    track_t          trk_d, trk_q;

    lsu_agen #(.XLEN(XLEN), .OFS_W(OFS_W)) u_agen (
        .valid    (req_valid),
        .store    (req_store),
        .width    (req_width),
        .base     (req_base),
        .offset   (req_offset),
        .ea       (ea),
        .size     (size),
        .uns      (uns),
        .misalign (misaligned),
        .access   (access)
    );

    lsu_wr_steer #(.XLEN(XLEN)) u_steer (
        .en    (access && req_store),
        .size  (size),
        .lane  (ea[LW-1:0]),
        .sdata (req_wdata),
        .we    (mem_we),
        .wdata (mem_wdata)
    );

    lsu_rd_extract #(.XLEN(XLEN)) u_extract (
        .rdata (mem_rdata),
        .size  (trk_q.size),
        .uns   (trk_q.uns),
        .lane  (trk_q.lane),
        .data  (ld_data)
    );

    always_comb begin
        trk_d      = trk_q;
        trk_d.done = access && !req_store;
        if (access && !req_store) begin
            trk_d.lane = ea[LW-1:0];
            trk_d.size = size;
            trk_d.uns  = uns;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{done: 1'b0, lane: '0, size: SZ_WORD, uns: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign mem_req  = access;
    assign mem_addr = {ea[XLEN-1:LW], {LW{1'b0}}};
    assign ld_done  = trk_q.done;

    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (mem_we == '0 && !mem_req)) else $error("misaligned access issued"); // R5
    AST_LOAD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |-> mem_we == '0) else $error("load wrote memory"); // R6
    AST_DONE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !req_store) |=> ld_done) else $error("load done missing"); // R7
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> $past(mem_req && !req_store)) else $error("spurious load done"); // R7
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_store && req_width == 3'b000) |-> $countones(mem_we) == 1)
        else $error("byte store lanes"); // R2
    AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_store && req_width == 3'b001) |-> $countones(mem_we) == 2)
        else $error("half store lanes"); // R3
    AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_store && req_width == 3'b010) |-> mem_we == '1)
        else $error("word store lanes"); // R4
    AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_width[1:0] == 2'b11) |-> (!mem_req && !misaligned))
        else $error("unsupported code accepted"); // R11
endmodule

// File: tb/sim_lsu_core.sv
module sim_lsu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [2:0]  req_width = 3'b000;
    logic [31:0] req_base = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        misaligned;
    logic        ld_done;
    logic [31:0] ld_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem   [16];
    logic [7:0]  shadow[64];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    lsu_core u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_width(req_width), .req_base(req_base), .req_offset(req_offset),
        .req_wdata(req_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .misaligned(misaligned), .ld_done(ld_done), .ld_data(ld_data)
    );

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        for (int i = 0; i < 64; i++) shadow[i] = '0;
    end

    // one-cycle synchronous memory model
    always @(posedge clk) begin
        if (mem_req) begin
            for (int l = 0; l < 4; l++)
                if (mem_we[l]) mem[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
            mem_rdata <= mem[mem_addr[5:2]];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: done is due one edge after the load request
    always @(posedge clk) begin
        #5;
        if (rst_n && ld_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(ld_data === e, t, ld_data, e);
            end
        end
    end

    function automatic logic [31:0] sext_ea(input logic [31:0] b, input logic [11:0] o);
        return b + {{20{o[11]}}, o};
    endfunction

    task automatic do_store(input logic [2:0] w, input logic [31:0] b, input logic [11:0] o,
                            input logic [31:0] d);
        logic [31:0] ea;
        logic        bad, mis;
        logic [3:0]  exp_we;
        logic [31:0] exp_wd;
        ea  = sext_ea(b, o);
        bad = (w[1:0] == 2'b11) || w[2];
        mis = !bad && ((w == 3'b001 && ea[0]) || (w == 3'b010 && ea[1:0] != 0));
        exp_we = '0;
        exp_wd = d;
        if (!bad && !mis) begin
            case (w)
                3'b000: begin exp_we = 4'b0001 << ea[1:0]; exp_wd = {4{d[7:0]}}; end
                3'b001: begin exp_we = ea[1] ? 4'b1100 : 4'b0011; exp_wd = {2{d[15:0]}}; end
                default: exp_we = 4'b1111;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b1; req_width = w;
        req_base = b; req_offset = o; req_wdata = d;
        #2;
        check(mem_we === exp_we, bad ? "R11 store we" : (mis ? "R5 store we" :
              (w == 3'b000 ? "R2 we" : (w == 3'b001 ? "R3 we" : "R4 we"))),
              {28'd0, mem_we}, {28'd0, exp_we});
        check(misaligned === mis, bad ? "R11 flag" : "R5 flag",
              {31'd0, misaligned}, {31'd0, mis});
        check(mem_req === (!bad && !mis), "R1/R5 store req", {31'd0, mem_req},
              {31'd0, !bad && !mis});
        if (!bad && !mis) begin
            check(mem_addr === {ea[31:2], 2'b00}, "R1 addr", mem_addr, {ea[31:2], 2'b00});
            check(mem_wdata === exp_wd, w == 3'b000 ? "R2 wdata" :
                  (w == 3'b001 ? "R3 wdata" : "R4 wdata"), mem_wdata, exp_wd);
            for (int k = 0; k < 4; k++)
                if (exp_we[k]) shadow[{ea[5:2], 2'(k)}] = exp_wd[8*k +: 8];
        end
    endtask

    task automatic do_load(input logic [2:0] w, input logic [31:0] b, input logic [11:0] o,
                           input string tag);
        logic [31:0] ea, e;
        logic        bad, mis;
        logic [7:0]  by;
        logic [15:0] hw;
        ea  = sext_ea(b, o);
        bad = (w[1:0] == 2'b11) || (w == 3'b110);
        mis = !bad && ((w[1:0] == 2'b01 && ea[0]) || (w == 3'b010 && ea[1:0] != 0));
        by  = shadow[ea[5:0]];
        hw  = {shadow[{ea[5:1], 1'b1}], shadow[{ea[5:1], 1'b0}]};
        case (w)
            3'b000: e = {{24{by[7]}}, by};
            3'b100: e = {24'd0, by};
            3'b001: e = {{16{hw[15]}}, hw};
            3'b101: e = {16'd0, hw};
            default: e = {shadow[{ea[5:2], 2'd3}], shadow[{ea[5:2], 2'd2}],
                          shadow[{ea[5:2], 2'd1}], shadow[{ea[5:2], 2'd0}]};
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_width = w;
        req_base = b; req_offset = o; req_wdata = 32'hFFFF_FFFF;
        #2;
        check(mem_we === 4'b0000, "R6 load we", {28'd0, mem_we}, 32'd0);
        check(misaligned === mis, bad ? "R11 load flag" : "R5 load flag",
              {31'd0, misaligned}, {31'd0, mis});
        check(mem_req === (!bad && !mis), "R1 load req", {31'd0, mem_req},
              {31'd0, !bad && !mis});
        if (!bad && !mis) begin
            check(mem_addr === {ea[31:2], 2'b00}, "R1 load addr", mem_addr, {ea[31:2], 2'b00});
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(ld_done === 1'b0, "R7 reset done", {31'd0, ld_done}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // word stores fill words with a negative offset (R4, R1)
        do_store(3'b010, 32'h0000_0024, 12'hFFC, 32'h8899_AABB);
        do_store(3'b010, 32'h0000_0024, 12'h000, 32'h1122_3344);
        do_load (3'b010, 32'h0000_0010, 12'h010, "R10 word");
        do_load (3'b010, 32'h0000_0030, 12'hFF4, "R10 word neg ofs");
        // byte stores into each lane (R2)
        for (int k = 0; k < 4; k++)
            do_store(3'b000, 32'h0000_0030, 12'(k), 32'h0000_0080 + 32'(k) * 32'h11);
        for (int k = 0; k < 4; k++) begin
            do_load(3'b000, 32'h0000_0030, 12'(k), "R8 signed byte");
            do_load(3'b100, 32'h0000_0030, 12'(k), "R8 unsigned byte");
        end
        // halfword stores at both halves (R3)
        do_store(3'b001, 32'h0000_0008, 12'h000, 32'hDEAD_F00D);
        do_store(3'b001, 32'h0000_0008, 12'h002, 32'h0000_1234);
        do_load (3'b001, 32'h0000_0008, 12'h000, "R9 signed half lo");
        do_load (3'b101, 32'h0000_0008, 12'h000, "R9 unsigned half lo");
        do_load (3'b001, 32'h0000_0008, 12'h002, "R9 signed half hi");
        do_load (3'b010, 32'h0000_0008, 12'h000, "R10 half pair word");
        do_load (3'b101, 32'h0000_0020, 12'h002, "R9 unsigned half hi");
        // misaligned (R5): nothing written, no done
        do_store(3'b001, 32'h0000_0008, 12'h001, 32'hFFFF_FFFF);
        do_store(3'b010, 32'h0000_0008, 12'h002, 32'hFFFF_FFFF);
        do_load (3'b010, 32'h0000_0009, 12'h000, "R5 word");
        do_load (3'b001, 32'h0000_0003, 12'h000, "R5 half");
        // unsupported codes (R11)
        do_store(3'b100, 32'h0000_0008, 12'h000, 32'hFFFF_FFFF);
        do_store(3'b011, 32'h0000_0008, 12'h000, 32'hFFFF_FFFF);
        do_load (3'b110, 32'h0000_0008, 12'h000, "R11 load");
        do_load (3'b111, 32'h0000_0008, 12'h000, "R11 load");
        // memory must be unchanged after R5/R11 attempts
        do_load (3'b010, 32'h0000_0008, 12'h000, "R5/R11 word intact");
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        #6;
        check(exp_q.size() == 0, "R7 pending done", 32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule